// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM Generator

This peripheral drives a small, parameterised number of pulse-width outputs from one common time base. A single 8-bit prescaler divides the system clock into local ticks, and a single 8-bit counter steps through 256 ticks per PWM period. Every channel compares that shared counter against its own 8-bit duty value. The output stays high while the counter is at or below the duty value, so the high time is the duty value plus one tick. A duty of 255 therefore holds the output high for the whole period, and no duty value produces a fully low output while the block runs.

Software reaches the block through 32-bit word-aligned registers, using a write strobe and a combinational read path. Duty registers sit at byte offset four times the channel index. The control word at 0x50 holds the prescaler, split into two separate 4-bit fields, and a global run bit. The interrupt-enable bit at 0x54 only reaches a pin. The live counter can be read at 0x58. Duty and prescaler values written while the block runs are held as pending values and take effect together at the next period boundary, so no period is ever cut short or stretched.

Top module: `pwm_shared_period`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and every PWM output is low.
- R2: The duty register of channel c sits at byte offset 4*c and holds 8 bits in rdata[7:0], with the upper bits reading zero. A write to a duty offset of a channel index at or above the channel count is ignored, and that offset reads zero.
- R3: The control word at 0x50 holds prescaler bits [3:0] in data bits [3:0], prescaler bits [7:4] in data bits [14:11], and the run bit in data bit 9. All other bits read zero.
- R4: Bit 0 of the word at 0x54 is stored, reads back, and drives the irq_en output. The other bits of that word read zero.
- R5: The word at 0x58 returns the shared period counter in bits [7:0] and ignores writes. Any other unmapped offset reads zero.
- R6: While the block is not running, all outputs are low and the counter reads zero. Clearing the run bit stops the outputs one clock after the write.
- R7: One clock after the write that sets the run bit, the counter starts at 0. It then advances by one every prescaler+1 clocks and wraps from 255 to 0.
- R8: Channel c is high while the counter is at or below its duty value N. That gives N+1 ticks high per 256-tick period: a duty of 0 gives one tick, and a duty of 255 gives a constant high.
- R9: Duty and prescaler writes made while running are applied together only when the counter wraps from 255 to 0. The period in progress keeps the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register word at reg_addr |
| reg_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq_en | output | 1 | Stored interrupt-enable bit |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
The bench goes after the duty extremes. A design that drops the plus-one tick would leave a duty of 0 fully low and would let a duty of 255 fall for one tick per period. It uses a prescaler with both nibbles set, which exposes a swapped or shifted split field as a wrong tick length. It changes duty and prescaler mid-period, and a design that applied them at once would show a clipped or stretched pulse in that period. It also writes to a duty offset beyond the channel count and to the read-only counter word. A loose decoder would corrupt a real channel or the counter.

// File: rtl/pwm_pkg.sv
// Package: shared constants of the shared-period PWM block.
// Assumes: word indices are byte offsets divided by four.
package pwm_pkg;
    localparam int CNT_W      = 8;   // period counter width (256 ticks)
    localparam int PSC_W      = 8;   // prescaler width
    localparam int DATA_W     = 32;  // register word width
    localparam int CTRL_WORD  = 20;  // byte offset 0x50
    localparam int IRQ_WORD   = 21;  // byte offset 0x54
    localparam int COUNT_WORD = 22;  // byte offset 0x58
    localparam int PSC_LO_LSB = 0;   // prescaler low nibble position
    localparam int PSC_HI_LSB = 11;  // prescaler high nibble position
    localparam int RUN_BIT    = 9;   // global run bit position
endpackage

// File: rtl/pwm_regs.sv
// Module: register file of the PWM block. Holds the pending duty values,
// the split prescaler, the run bit and the interrupt enable, and muxes read data.
// Assumes: NUM_CH <= 20 so duty offsets stay below the control word.
module pwm_regs #(
    parameter int NUM_CH = 1,
    parameter int ADDR_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [pwm_pkg::DATA_W-1:0]      wdata,
    input  logic [pwm_pkg::CNT_W-1:0]       cnt,
    output logic [pwm_pkg::DATA_W-1:0]      rdata,
    output logic [NUM_CH-1:0][pwm_pkg::CNT_W-1:0] duty_pend,
    output logic [pwm_pkg::PSC_W-1:0]       psc_pend,
    output logic                            run_req,
    output logic                            irq_q
);
    import pwm_pkg::*;
    localparam int WORD_W = ADDR_W - 2;
    localparam logic [WORD_W-1:0] CTRL_W  = WORD_W'(CTRL_WORD);
    localparam logic [WORD_W-1:0] IRQ_W   = WORD_W'(IRQ_WORD);
    localparam logic [WORD_W-1:0] COUNT_W = WORD_W'(COUNT_WORD);

    logic [WORD_W-1:0] word;
    logic [CNT_W-1:0]  duty_q [NUM_CH];
    logic              unused_bits;

    assign word        = addr[ADDR_W-1:2];
    assign unused_bits = ^{addr[1:0], wdata[31:15], wdata[10], wdata[8:4]};

    // Capture writes into the duty, control and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) duty_q[c] <= '0;
            psc_pend <= '0;
            run_req  <= 1'b0;
            irq_q    <= 1'b0;
        end else if (wr) begin
            for (int c = 0; c < NUM_CH; c++)
                if (word == WORD_W'(c)) duty_q[c] <= wdata[CNT_W-1:0];
            if (word == CTRL_W) begin
                psc_pend <= {wdata[PSC_HI_LSB+3:PSC_HI_LSB], wdata[PSC_LO_LSB+3:PSC_LO_LSB]};
                run_req  <= wdata[RUN_BIT];
            end
            if (word == IRQ_W) irq_q <= wdata[0];
        end
    end

    // Flatten the duty array onto the packed output bus.
    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_flat
            assign duty_pend[g] = duty_q[g];
        end
    endgenerate

    // Select read data for the addressed word; unmapped words read zero.
    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (word == WORD_W'(c)) rdata[CNT_W-1:0] = duty_q[c];
        if (word == CTRL_W) begin
            rdata[PSC_LO_LSB+3:PSC_LO_LSB] = psc_pend[3:0];
            rdata[PSC_HI_LSB+3:PSC_HI_LSB] = psc_pend[7:4];
            rdata[RUN_BIT]                 = run_req;
        end
        if (word == IRQ_W)   rdata[0]         = irq_q;
        if (word == COUNT_W) rdata[CNT_W-1:0] = cnt;
    end

    assert_irq_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word == IRQ_W) |=> (irq_q == $past(wdata[0])));
    assert_run_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && word == CTRL_W) |=> (run_req == $past(wdata[RUN_BIT])));
    assert_ctrl_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && word == CTRL_W) |=> ($stable(psc_pend) && $stable(run_req)));
endmodule

// File: rtl/pwm_timebase.sv
// Module: shared time base. Divides the clock by the active prescaler plus one
// and steps the 256-tick period counter. Raises reload at start and at each wrap.
// Assumes: run_req comes from a register; counting starts one clock after it rises.
module pwm_timebase (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        run_req,
    input  logic [pwm_pkg::PSC_W-1:0]   psc_pend,
    output logic [pwm_pkg::CNT_W-1:0]   cnt,
    output logic                        running,
    output logic                        reload
);
    import pwm_pkg::*;
    logic [PSC_W-1:0] psc_act;
    logic [PSC_W-1:0] div_q;
    logic             tick;

    assign tick   = running && (div_q == psc_act);
    assign reload = !running || (tick && (cnt == '1));

    // Track the running state one clock behind the run request.
    always_ff @(posedge clk) begin
        if (!rst_n) running <= 1'b0;
        else        running <= run_req;
    end

    // Adopt the pending prescaler while idle and at each period wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)      psc_act <= '0;
        else if (reload) psc_act <= psc_pend;
    end

    // Advance the clock divider and the period counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_req || !running) begin
            div_q <= '0;
            cnt   <= '0;
        end else if (tick) begin
            div_q <= '0;
            cnt   <= cnt + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (cnt == '0 && div_q == '0));
    assert_div_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (div_q <= psc_act));
    assert_cnt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_req && !tick) |=> $stable(cnt));
    assert_cnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && run_req && tick) |=> (cnt == $past(cnt) + 1'b1));
    assert_psc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(psc_act));
endmodule

// File: rtl/pwm_channel.sv
// Module: one PWM output. Holds the active duty value, loaded at reload,
// and drives high while the shared counter is at or below it.
// Assumes: cnt, running and reload come from the shared time base.
module pwm_channel (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        running,
    input  logic                        reload,
    input  logic [pwm_pkg::CNT_W-1:0]   duty_pend,
    input  logic [pwm_pkg::CNT_W-1:0]   cnt,
    output logic                        pwm
);
    import pwm_pkg::*;
    logic [CNT_W-1:0] duty_act;

    // Take the pending duty only at the period boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)      duty_act <= '0;
        else if (reload) duty_act <= duty_pend;
    end

    // Compare the shared counter against the active duty.
    assign pwm = running && (cnt <= duty_act);

    assert_duty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reload |=> $stable(duty_act));
    assert_full_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && duty_act == '1) |-> pwm);
endmodule

// File: rtl/pwm_shared_period.sv
// Module: top of the shared-period PWM block. Ties the register file, the
// shared time base and one comparator per channel together.
// Assumes: 1 <= NUM_CH <= 20, ADDR_W >= 7.
module pwm_shared_period #(
    parameter int NUM_CH = 1,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_en,
    output logic [NUM_CH-1:0] pwm_out
);
    import pwm_pkg::*;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_pend;
    logic [PSC_W-1:0]             psc_pend;
    logic [CNT_W-1:0]             cnt;
    logic                         run_req;
    logic                         running;
    logic                         reload;

    pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .cnt(cnt), .rdata(reg_rdata),
        .duty_pend(duty_pend), .psc_pend(psc_pend),
        .run_req(run_req), .irq_q(irq_en)
    );

    pwm_timebase u_base (
        .clk(clk), .rst_n(rst_n), .run_req(run_req), .psc_pend(psc_pend),
        .cnt(cnt), .running(running), .reload(reload)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            pwm_channel u_ch (
                .clk(clk), .rst_n(rst_n), .running(running), .reload(reload),
                .duty_pend(duty_pend[g]), .cnt(cnt), .pwm(pwm_out[g])
            );
        end
    endgenerate

    assert_off_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run_req) |=> (pwm_out == '0));
endmodule

// File: tb/pwm_shared_period_bench.sv
module pwm_shared_period_bench;
    localparam int NCH = 3;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [7:0] reg_addr = 8'h58;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic irq_en;
    logic [NCH-1:0] pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    // bench model of the requirements
    bit running = 0;
    bit en_m = 0;
    int k = 0;
    int p_cur = 0, p_pend = 0;
    int d_cur [NCH];
    int d_pend [NCH];

    always #2 clk = ~clk;   // 250 MHz

    pwm_shared_period #(.NUM_CH(NCH), .ADDR_W(8)) u_pwm_shared_period (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_en(irq_en),
        .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int tick_idx(input int kk, input int p);
        return kk / (p + 1);
    endfunction

    function automatic bit exp_out(input int c);
        return running && (tick_idx(k, p_cur) <= d_cur[c]);
    endfunction

    // model: advance the clock count, adopt pending values at each wrap (R9)
    always @(posedge clk) begin
        if (running) begin
            k = k + 1;
            if (k == 256 * (p_cur + 1)) begin
                k = 0;
                p_cur = p_pend;
                for (int c = 0; c < NCH; c++) d_cur[c] = d_pend[c];
            end
        end
    end

    // compare outputs and the counter word away from the clock edge
    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++)
                check(pwm_out[c] == exp_out(c), running ? "R8" : "R6",
                      int'(pwm_out[c]), int'(exp_out(c)));
            if (!reg_wr && reg_addr == 8'h58)
                check(reg_rdata == 32'(running ? tick_idx(k, p_cur) : 0), "R7",
                      int'(reg_rdata), running ? tick_idx(k, p_cur) : 0);
        end
    end

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_addr = 8'h58;
        if (a[1:0] == 2'b00 && int'(a[7:2]) < NCH) d_pend[a[7:2]] = int'(d[7:0]);
        if (a == 8'h50) begin
            p_pend = int'({d[14:11], d[3:0]});
            if (d[9] && !en_m) begin
                en_m = 1;
                @(posedge clk); #1;
                running = 1; k = 0; p_cur = p_pend;
                for (int c = 0; c < NCH; c++) d_cur[c] = d_pend[c];
            end else if (!d[9] && en_m) begin
                en_m = 0;
                @(posedge clk); #1;
                running = 0; k = 0;
            end
        end
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        check(reg_rdata == e, req, int'(reg_rdata), int'(e));
        #1 reg_addr = 8'h58;
    endtask

    function automatic logic [31:0] ctrl_word(input int p, input bit run);
        logic [31:0] w = '0;
        w[3:0]   = 4'(p);
        w[14:11] = 4'(p >> 4);
        w[9]     = run;
        return w;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'h0BAD_5EED));
        for (int c = 0; c < NCH; c++) begin d_cur[c] = 0; d_pend[c] = 0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        for (int c = 0; c < NCH; c++) rd_chk(8'(4 * c), 32'h0, "R1");
        rd_chk(8'h50, 32'h0, "R1");
        rd_chk(8'h54, 32'h0, "R1");
        @(negedge clk);
        check(pwm_out == '0 && irq_en == 1'b0, "R1", int'(pwm_out), 0);
        // R2: duty registers and the offset past the last channel
        wr_reg(8'h00, 32'hFFFF_FF5A);
        wr_reg(8'h04, 32'h0000_0033);
        wr_reg(8'h08, 32'h1234_56C3);
        wr_reg(8'(4 * NCH), 32'h0000_00EE);
        rd_chk(8'h00, 32'h5A, "R2");
        rd_chk(8'h04, 32'h33, "R2");
        rd_chk(8'h08, 32'hC3, "R2");
        rd_chk(8'(4 * NCH), 32'h0, "R2");
        // R3: split prescaler fields, reserved bits read zero
        wr_reg(8'h50, 32'hFFFF_FDFF);
        rd_chk(8'h50, 32'h0000_780F, "R3");
        wr_reg(8'h50, 32'h0);
        rd_chk(8'h50, 32'h0, "R3");
        // R4: interrupt enable
        wr_reg(8'h54, 32'hFFFF_FFFF);
        rd_chk(8'h54, 32'h1, "R4");
        @(negedge clk); check(irq_en == 1'b1, "R4", int'(irq_en), 1);
        wr_reg(8'h54, 32'h0);
        @(negedge clk); check(irq_en == 1'b0, "R4", int'(irq_en), 0);
        // R5: counter word is read-only, unmapped words read zero
        wr_reg(8'h58, 32'h0000_00AB);
        rd_chk(8'h58, 32'h0, "R5");
        rd_chk(8'h5C, 32'h0, "R5");
        rd_chk(8'h40, 32'h0, "R5");
        rd_chk(8'h04, 32'h33, "R5");
        // R6: idle outputs stay low
        repeat (40) @(posedge clk);
        // R8: duty extremes with prescaler 0
        wr_reg(8'h00, 32'h00);
        wr_reg(8'h04, 32'hFF);
        wr_reg(8'h08, 32'h80);
        wr_reg(8'h50, ctrl_word(0, 1));
        repeat (600) @(posedge clk);
        wr_reg(8'h50, ctrl_word(0, 0));
        repeat (20) @(posedge clk);
        // R3/R7: prescaler with both nibbles set
        wr_reg(8'h50, ctrl_word(8'h11, 1));
        repeat (5000) @(posedge clk);
        // R9: mid-period duty and prescaler change
        wr_reg(8'h04, 32'h10);
        wr_reg(8'h50, ctrl_word(1, 1));
        repeat (5000) @(posedge clk);
        wr_reg(8'h50, ctrl_word(1, 0));
        repeat (30) @(posedge clk);
        // random configurations
        for (int it = 0; it < 12; it++) begin
            int p;
            p = int'($urandom % 4);
            for (int c = 0; c < NCH; c++) wr_reg(8'(4 * c), $urandom);
            wr_reg(8'h50, ctrl_word(p, 1));
            repeat (int'($urandom % 300) + 100) @(posedge clk);
            wr_reg(8'(4 * ($urandom % NCH)), $urandom);
            repeat (2 * 256 * (p + 1)) @(posedge clk);
            wr_reg(8'h50, ctrl_word(p, 0));
            repeat (10) @(posedge clk);
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule